// File: doc/BRIEF.md
# Drive Status and Attention Reporter

This block keeps one 16-bit condition register for each drive on a multi-drive disk controller. Other parts of the controller send it per-drive set and clear masks when seeks end, errors appear or a transfer overruns. When the command decoder asks for a status check on one drive, the block builds the word for the host from that drive's stored conditions, its write-protect input and its heads-loaded input. It then clears the conditions that have been reported and turns attention polling back on.

The block also drives a combinational attention vector, one bit per drive, for the command channel's input path. It raises a one-cycle command-flag request when the host has to be told about pending attention, and it handles head-load events. A control reset keeps only the first-status condition of attached drives. Command decoding and data movement are handled elsewhere.

Top module: `drive_status_reporter`

## Requirements
- R1: One cycle after `status_rd`, `stat_valid` is 1 and `stat_word` holds the selected loaded drive's stored bits. Bits 15, 12 and 9 read as 0, and bit 10 equals that drive's `wprot` input instead of the stored bit 10.
- R2: Bit 0 of the returned word is 1 exactly when any of bits 15, 14, 13, 12, 11, 9, 8, 6, 5, 4, 3, 2 or 1 of the returned word is 1 (mask 0xFB7E). Write-protect (bit 10) alone leaves bit 0 at 0.
- R3: A status read of a drive whose `heads_loaded` input is 0 returns 0x0045: not ready (bit 6), busy (bit 2) and the summary bit 0.
- R4: A status read clears bits 15, 14, 13, 12, 11, 5, 4, 3 and 1 (mask 0xF83A) of the selected drive. All other bits of that drive and all other drives are unchanged.
- R5: `poll_en` becomes 1 after a status read or `poll_arm`, and becomes 0 after `poll_disarm`. `poll_disarm` wins over the other two in the same cycle.
- R6: A status read raises `cmd_flag_req` for one cycle, one cycle later, if any drive other than the selected one had bit 15 set before the read.
- R7: `attn_vec[i]` equals bit 15 of drive i's stored register.
- R8: `load_pulse[i]` sets bits 15 and 14 of drive i. It raises `cmd_flag_req` one cycle later if `poll_en` was 1 in the cycle of the pulse.
- R9: `soft_rst` keeps bit 14 of drives whose `attached` bit is 1, clears every other stored bit, clears `poll_en` and `cmd_flag_req`, and overrides every other input in that cycle.
- R10: A status read of an unloaded drive clears the bits of R4 and sets polling exactly as a read of a loaded drive does.
- R11: Bits in `cond_set` (drive i at bits 16*i+15 down to 16*i) are set and bits in `cond_clr` are cleared in the next cycle. When both hit the same bit, set wins. These masks apply after the R4 clear of the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low power-on reset, clears everything |
| soft_rst | input | 1 | Synchronous control reset (R9) |
| attached | input | N | Drive has media attached |
| heads_loaded | input | N | Drive heads are loaded |
| wprot | input | N | Drive is write protected |
| load_pulse | input | N | Heads-load event per drive |
| cond_set | input | 16*N | Per-drive condition set mask |
| cond_clr | input | 16*N | Per-drive condition clear mask |
| status_rd | input | 1 | Status check request |
| drv_sel | input | SEL_W | Drive addressed by the status check |
| poll_arm | input | 1 | Enable attention polling |
| poll_disarm | input | 1 | Disable attention polling |
| stat_word | output | 16 | Returned status word |
| stat_valid | output | 1 | `stat_word` updated this cycle |
| attn_vec | output | N | Attention bit of every drive |
| cmd_flag_req | output | 1 | One-cycle command-flag request |
| poll_en | output | 1 | Attention polling enabled |

## Verification
The bench goes after the summary bit with write-protect alone set. A design that counts bit 10 in the error set would return 0x0401 instead of 0x0400. It reads a drive with bits 15, 12 and 9 stored to catch a leak of the always-zero bits. It reads busy twice to catch a design that wrongly clears busy on read. Reads of unloaded drives must both return 0x0045 and still clear and re-arm. A control reset must keep first-status only on attached drives, and a set mask that meets a clear mask must end set. Random mixes of reads, loads, masks and polling controls check the flag request: a design that counted the selected drive's own attention, or ignored the poll state on a load, would raise or drop the request.

// File: rtl/dsr_pkg.sv
package dsr_pkg;
   localparam int STAT_W = 16;
   typedef logic [STAT_W-1:0] stat_t;

   localparam int B_ATTN  = 15;
   localparam int B_FIRST = 14;
   localparam int B_WPROT = 10;
   localparam int B_SUM   = 0;

   // conditions cleared once reported
   localparam stat_t RD_CLR_MASK   = 16'hF83A;
   // conditions that raise the summary bit
   localparam stat_t ERR_SET_MASK  = 16'hFB7E;
   // bits forced low in the returned word
   localparam stat_t ZERO_MASK     = 16'h9200;
   // word for a drive whose heads are off the platter
   localparam stat_t UNLOADED_WORD = 16'h0045;
   localparam stat_t LOAD_SET_MASK = stat_t'((1 << B_ATTN) | (1 << B_FIRST));
   localparam stat_t FIRST_MASK    = stat_t'(1 << B_FIRST);
endpackage

// File: rtl/dsr_drive_cell.sv
module dsr_drive_cell
   import dsr_pkg::*;
(
   input  logic  clk,
   input  logic  rst_n,
   input  logic  soft_rst,
   input  logic  attached,
   input  logic  rd_hit,
   input  logic  load_evt,
   input  stat_t set_mask,
   input  stat_t clr_mask,
   output stat_t cond_q
);
   stat_t rd_clr;
   stat_t load_set;
   stat_t cond_d;

   always_comb begin
      rd_clr   = rd_hit   ? RD_CLR_MASK   : '0;
      load_set = load_evt ? LOAD_SET_MASK : '0;
      if (soft_rst)
         cond_d = attached ? (cond_q & FIRST_MASK) : '0;
      else
         cond_d = (cond_q & ~rd_clr & ~clr_mask) | set_mask | load_set;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) cond_q <= '0;
      else        cond_q <= cond_d;
   end
endmodule

// File: rtl/dsr_word_former.sv
module dsr_word_former
   import dsr_pkg::*;
#(
   parameter int N     = 4,
   parameter int SEL_W = 2
)(
   input  stat_t            cond_all [N],
   input  logic [N-1:0]     heads_loaded,
   input  logic [N-1:0]     wprot,
   input  logic [SEL_W-1:0] drv_sel,
   output stat_t            word
);
   stat_t sel_cond;
   logic  sel_loaded;
   logic  sel_wp;
   stat_t body;

   always_comb begin
      sel_cond   = '0;
      sel_loaded = 1'b0;
      sel_wp     = 1'b0;
      for (int i = 0; i < N; i++) begin
         if (SEL_W'(i) == drv_sel) begin
            sel_cond   = cond_all[i];
            sel_loaded = heads_loaded[i];
            sel_wp     = wprot[i];
         end
      end
      body = sel_cond & ~ZERO_MASK & ~stat_t'(1 << B_WPROT) & ~stat_t'(1 << B_SUM);
      body[B_WPROT] = sel_wp;
      body[B_SUM]   = |(body & ERR_SET_MASK);
      word = sel_loaded ? body : UNLOADED_WORD;
   end
endmodule

// File: rtl/dsr_flag_ctrl.sv
module dsr_flag_ctrl #(
   parameter int N     = 4,
   parameter int SEL_W = 2
)(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             soft_rst,
   input  logic             status_rd,
   input  logic [SEL_W-1:0] drv_sel,
   input  logic [N-1:0]     attn,
   input  logic [N-1:0]     load_pulse,
   input  logic             poll_arm,
   input  logic             poll_disarm,
   output logic             poll_en,
   output logic             cmd_flag_req
);
   logic other_attn;
   logic flag_d;
   logic poll_d;

   always_comb begin
      other_attn = 1'b0;
      for (int i = 0; i < N; i++)
         if (SEL_W'(i) != drv_sel && attn[i]) other_attn = 1'b1;
      flag_d = !soft_rst && ((status_rd && other_attn) || (|load_pulse && poll_en));
      if (soft_rst || poll_disarm)    poll_d = 1'b0;
      else if (status_rd || poll_arm) poll_d = 1'b1;
      else                            poll_d = poll_en;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         poll_en      <= 1'b0;
         cmd_flag_req <= 1'b0;
      end else begin
         poll_en      <= poll_d;
         cmd_flag_req <= flag_d;
      end
   end
endmodule

// File: rtl/drive_status_reporter.sv
module drive_status_reporter
   import dsr_pkg::*;
#(
   parameter int N     = 4,
   parameter int SEL_W = (N > 1) ? $clog2(N) : 1
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              soft_rst,
   input  logic [N-1:0]      attached,
   input  logic [N-1:0]      heads_loaded,
   input  logic [N-1:0]      wprot,
   input  logic [N-1:0]      load_pulse,
   input  logic [16*N-1:0]   cond_set,
   input  logic [16*N-1:0]   cond_clr,
   input  logic              status_rd,
   input  logic [SEL_W-1:0]  drv_sel,
   input  logic              poll_arm,
   input  logic              poll_disarm,
   output logic [15:0]       stat_word,
   output logic              stat_valid,
   output logic [N-1:0]      attn_vec,
   output logic              cmd_flag_req,
   output logic              poll_en
);
   localparam int SW = STAT_W;

   if (N < 2 || N > 16) begin : g_bad_n
      $error("drive_status_reporter: N must lie in 2..16");
   end
   if ((1 << SEL_W) < N) begin : g_bad_sel
      $error("drive_status_reporter: SEL_W too narrow for N");
   end

   stat_t cond_q [N];
   stat_t word_c;
   logic  rd_eff;

   assign rd_eff = status_rd && !soft_rst;

   for (genvar i = 0; i < N; i++) begin : g_drv
      dsr_drive_cell u_cell (
         .clk      (clk),
         .rst_n    (rst_n),
         .soft_rst (soft_rst),
         .attached (attached[i]),
         .rd_hit   (rd_eff && (drv_sel == SEL_W'(i))),
         .load_evt (load_pulse[i]),
         .set_mask (cond_set[SW*i +: SW]),
         .clr_mask (cond_clr[SW*i +: SW]),
         .cond_q   (cond_q[i])
      );
      assign attn_vec[i] = cond_q[i][B_ATTN];
   end

   dsr_word_former #(.N(N), .SEL_W(SEL_W)) u_word (
      .cond_all     (cond_q),
      .heads_loaded (heads_loaded),
      .wprot        (wprot),
      .drv_sel      (drv_sel),
      .word         (word_c)
   );

   dsr_flag_ctrl #(.N(N), .SEL_W(SEL_W)) u_flag (
      .clk          (clk),
      .rst_n        (rst_n),
      .soft_rst     (soft_rst),
      .status_rd    (rd_eff),
      .drv_sel      (drv_sel),
      .attn         (attn_vec),
      .load_pulse   (load_pulse),
      .poll_arm     (poll_arm),
      .poll_disarm  (poll_disarm),
      .poll_en      (poll_en),
      .cmd_flag_req (cmd_flag_req)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         stat_word  <= '0;
         stat_valid <= 1'b0;
      end else begin
         stat_valid <= rd_eff;
         if (rd_eff) stat_word <= word_c;
      end
   end
endmodule

// File: rtl/dsr_checker.sv
module dsr_checker #(
   parameter int N     = 4,
   parameter int SEL_W = 2
)(
   input logic             clk,
   input logic             rst_n,
   input logic             soft_rst,
   input logic [N-1:0]     heads_loaded,
   input logic [N-1:0]     load_pulse,
   input logic [16*N-1:0]  cond_set,
   input logic             status_rd,
   input logic [SEL_W-1:0] drv_sel,
   input logic             poll_disarm,
   input logic [15:0]      stat_word,
   input logic             stat_valid,
   input logic [N-1:0]     attn_vec,
   input logic             cmd_flag_req,
   input logic             poll_en
);
   assert_zero_bits_R1: assert property (@(posedge clk) disable iff (!rst_n)
      stat_valid |-> (stat_word[15] == 1'b0 && stat_word[12] == 1'b0 && stat_word[9] == 1'b0));

   assert_summary_R2: assert property (@(posedge clk) disable iff (!rst_n)
      stat_valid |-> (stat_word[0] == |(stat_word & 16'hFB7E)));

   assert_unloaded_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (status_rd && !soft_rst && !heads_loaded[drv_sel]) |=> (stat_word == 16'h0045));

   assert_attn_clear_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (status_rd && !soft_rst && !load_pulse[drv_sel] && !cond_set[{drv_sel, 4'hF}])
      |=> !attn_vec[$past(drv_sel)]);

   assert_rearm_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (status_rd && !soft_rst && !poll_disarm) |=> poll_en);

   assert_disarm_R5: assert property (@(posedge clk) disable iff (!rst_n)
      poll_disarm |=> !poll_en);

   assert_load_flag_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (|load_pulse && poll_en && !soft_rst) |=> cmd_flag_req);

   assert_soft_reset_R9: assert property (@(posedge clk) disable iff (!rst_n)
      soft_rst |=> (attn_vec == '0 && !poll_en && !cmd_flag_req && !stat_valid));
endmodule

bind drive_status_reporter dsr_checker #(.N(N), .SEL_W(SEL_W)) chk_i (
   .clk          (clk),
   .rst_n        (rst_n),
   .soft_rst     (soft_rst),
   .heads_loaded (heads_loaded),
   .load_pulse   (load_pulse),
   .cond_set     (cond_set),
   .status_rd    (status_rd),
   .drv_sel      (drv_sel),
   .poll_disarm  (poll_disarm),
   .stat_word    (stat_word),
   .stat_valid   (stat_valid),
   .attn_vec     (attn_vec),
   .cmd_flag_req (cmd_flag_req),
   .poll_en      (poll_en)
);

// File: tb/drive_status_reporter_tb_top.sv
module drive_status_reporter_tb_top;
   localparam int N = 4;
   localparam int SEL_W = 2;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic soft_rst = 1'b0;
   logic [N-1:0] attached = '0, heads_loaded = '0, wprot = '0, load_pulse = '0;
   logic [16*N-1:0] cond_set = '0, cond_clr = '0;
   logic status_rd = 1'b0;
   logic [SEL_W-1:0] drv_sel = '0;
   logic poll_arm = 1'b0, poll_disarm = 1'b0;
   logic [15:0] stat_word;
   logic stat_valid;
   logic [N-1:0] attn_vec;
   logic cmd_flag_req, poll_en;

   int n_tests = 0;
   int n_fail = 0;
   int cycles = 0;

   logic [15:0] mst [N];
   logic mpoll;
   logic eflag, evalid;
   logic [15:0] eword;

   always #5 clk = ~clk;

   drive_status_reporter #(.N(N)) dut_i (
      .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst), .attached(attached),
      .heads_loaded(heads_loaded), .wprot(wprot), .load_pulse(load_pulse),
      .cond_set(cond_set), .cond_clr(cond_clr), .status_rd(status_rd),
      .drv_sel(drv_sel), .poll_arm(poll_arm), .poll_disarm(poll_disarm),
      .stat_word(stat_word), .stat_valid(stat_valid), .attn_vec(attn_vec),
      .cmd_flag_req(cmd_flag_req), .poll_en(poll_en));

   always @(posedge clk) begin
      cycles <= cycles + 1;
      if (cycles > 100000) begin
         n_fail = n_fail + 1;
         $display("FAIL watchdog expired: got %0d cycles exp fewer", cycles);
         $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end

   task automatic check(string tag, logic [15:0] got, logic [15:0] exp);
      n_tests++;
      if (got !== exp) begin
         n_fail++;
         $display("FAIL %s: got %h exp %h", tag, got, exp);
      end
   endtask

   function automatic logic [15:0] form_word(logic [15:0] st, logic ld, logic wp);
      logic [15:0] w;
      if (!ld) return 16'h0045;
      w = st & ~16'h9200 & ~16'h0401;
      w[10] = wp;
      w[0] = |(w & 16'hFB7E);
      return w;
   endfunction

   // advance model to the state after the coming edge
   task automatic model_edge();
      logic other;
      logic [15:0] n;
      evalid = 1'b0;
      eflag = 1'b0;
      if (soft_rst) begin
         for (int i = 0; i < N; i++) mst[i] = attached[i] ? (mst[i] & 16'h4000) : 16'h0;
         mpoll = 1'b0;
      end else begin
         other = 1'b0;
         for (int i = 0; i < N; i++) if (i != drv_sel && mst[i][15]) other = 1'b1;
         evalid = status_rd;
         if (status_rd) eword = form_word(mst[drv_sel], heads_loaded[drv_sel], wprot[drv_sel]);
         eflag = (status_rd && other) || (|load_pulse && mpoll);
         for (int i = 0; i < N; i++) begin
            n = mst[i];
            if (status_rd && i == drv_sel) n = n & ~16'hF83A;
            n = (n & ~cond_clr[16*i +: 16]) | cond_set[16*i +: 16];
            if (load_pulse[i]) n = n | 16'hC000;
            mst[i] = n;
         end
         if (poll_disarm) mpoll = 1'b0;
         else if (status_rd || poll_arm) mpoll = 1'b1;
      end
   endtask

   // inputs are already set (at a negedge); clock once and compare
   task automatic step();
      logic [N-1:0] ea;
      model_edge();
      @(negedge clk);
      for (int i = 0; i < N; i++) ea[i] = mst[i][15];
      check("R7 attention vector", 16'(attn_vec), 16'(ea));
      check("R5 poll enable", 16'(poll_en), 16'(mpoll));
      check("R6/R8 flag request", 16'(cmd_flag_req), 16'(eflag));
      check("R1 valid strobe", 16'(stat_valid), 16'(evalid));
      if (evalid) check("R1 status word", stat_word, eword);
      soft_rst = 0; load_pulse = '0; cond_set = '0; cond_clr = '0;
      status_rd = 0; poll_arm = 0; poll_disarm = 0;
   endtask

   task automatic rd(int d);
      status_rd = 1'b1;
      drv_sel = SEL_W'(d);
      step();
   endtask

   initial begin
      void'($urandom(32'd7331));
      for (int i = 0; i < N; i++) mst[i] = '0;
      mpoll = 1'b0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      check("R9 reset attention", 16'(attn_vec), 16'h0);
      check("R5 reset poll", 16'(poll_en), 16'h0);

      // R3 / R10: unloaded drive returns fixed word and re-arms
      cond_set[16*1 +: 16] = 16'h8020;
      step();
      rd(1);
      check("R3 unloaded word", stat_word, 16'h0045);
      check("R10 unloaded read clears attention", 16'(attn_vec[1]), 16'h0);
      check("R10 unloaded read re-arms polling", 16'(poll_en), 16'h1);
      rd(1);
      check("R10 end-of-cylinder cleared", stat_word, 16'h0045);

      // R8: head load with polling on
      heads_loaded = '1;
      load_pulse[2] = 1'b1;
      step();
      check("R8 load flag", 16'(cmd_flag_req), 16'h1);
      check("R8 load attention", 16'(attn_vec), 16'h4);

      // R1 / R6: forced-zero bits, other drive attention
      cond_set[0 +: 16] = 16'h9600;
      step();
      rd(0);
      check("R1 forced zero and wp input", stat_word, 16'h0000);
      check("R6 flag from other drive", 16'(cmd_flag_req), 16'h1);
      check("R4 attention cleared", 16'(attn_vec), 16'h4);

      // R2: write-protect alone, then busy which must survive a read
      wprot[3] = 1'b1;
      rd(3);
      check("R2 wp excluded from summary", stat_word, 16'h0400);
      cond_set[16*3 +: 16] = 16'h0004;
      step();
      rd(3);
      check("R2 busy sets summary", stat_word, 16'h0405);
      rd(3);
      check("R4 busy kept on read", stat_word, 16'h0405);

      // R11: set beats clear
      cond_set[16*1 +: 16] = 16'h0100;
      cond_clr[16*1 +: 16] = 16'h0100;
      step();
      rd(1);
      check("R11 set wins", stat_word, 16'h0101);

      // R9: soft reset keeps first status on attached drive
      attached = 4'b0100;
      cond_set[16*0 +: 16] = 16'h4000;
      step();
      soft_rst = 1'b1;
      load_pulse = 4'b0001;
      status_rd = 1'b1;
      step();
      check("R9 soft reset attention", 16'(attn_vec), 16'h0);
      rd(2);
      check("R9 attached keeps first status", stat_word, 16'h4001);
      rd(0);
      check("R9 unattached cleared", stat_word, 16'h0000);

      // random mix
      for (int k = 0; k < 3000; k++) begin
         attached     = N'($urandom);
         heads_loaded = N'($urandom) | N'($urandom);
         wprot        = N'($urandom);
         for (int i = 0; i < N; i++) begin
            if ($urandom_range(3) == 0) cond_set[16*i +: 16] = 16'($urandom);
            if ($urandom_range(3) == 0) cond_clr[16*i +: 16] = 16'($urandom);
         end
         load_pulse  = ($urandom_range(7) == 0) ? N'($urandom) : '0;
         status_rd   = ($urandom_range(2) == 0);
         drv_sel     = SEL_W'($urandom);
         poll_arm    = ($urandom_range(9) == 0);
         poll_disarm = ($urandom_range(9) == 0);
         soft_rst    = ($urandom_range(49) == 0);
         step();
      end

      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end
endmodule